// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a programmable watchdog. It counts down on pulses from a slow reference tick of about 32 kHz, which is presented as a single-cycle enable in the block's clock domain. The pulses pass through a power-of-two prescaler before they reach the counter. Software programs the block through a small register port. The port holds a 16-bit timeout, a 16-bit configuration word and an 8-bit status byte.

When the counter runs out, the block raises a first event and reloads. If software does not service it before the next expiry, the block raises a second event. Each event is chosen independently: it can do nothing, raise an interrupt, request a system-management interrupt, or pulse a system reset. Sticky status flags record the overflow and each output that fired. Writing a 1 to the overflow flag acknowledges everything and rearms the first stage.

Top module: `wdog_top`

## Requirements
- R1: After reset, the timeout, configuration and status registers all read 0. The interrupt, SMI and reset outputs are low, and the counter is stopped.
- R2: Reads are combinational. Address 0x00 returns the timeout. Address 0x02 returns the configuration. Address 0x04 returns the status in bits 7:0 with zeros above. Any other address returns 0.
- R3: Configuration bits 15:9 and status bits 7:4 are reserved. Writes leave them unchanged, so they always read 0.
- R4: The counter decrements once every 2^E counted tick pulses, where E is configuration bits 3:0. Settings 14 and 15 behave as 13.
- R5: While configuration bit 8 is 1, tick pulses are not counted and the prescaler and counter hold their values.
- R6: A write to the timeout register loads the counter with the written value, clears the prescaler and rearms the first stage. A tick in that same cycle is ignored. A timeout of 0 stops counting.
- R7: On the T-th prescaled decrement after a load (T being the timeout), the counter expires, sets status bit 0 and reloads from the timeout. The first expiry raises the action in configuration bits 5:4. Every later expiry before an acknowledge raises the action in bits 7:6. The action encoding is 00 none, 01 interrupt, 10 SMI, 11 reset.
- R8: The interrupt and SMI outputs are levels, set on the clock edge of the expiry that selects them. They are mirrored in status bits 1 and 2 and held until acknowledged.
- R9: A reset action drives the reset output high for exactly the one cycle after the expiry edge and sets status bit 3. Status bit 3 stays set after the pulse ends.
- R10: Writing status with bit 0 = 1 clears status bits 3:0, drops the interrupt and SMI outputs and rearms the first stage. A tick in that cycle is ignored. A status write with bit 0 = 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low power-on reset |
| tickIn | input | 1 | One-cycle pulse per reference tick (~32 kHz) |
| busWrite | input | 1 | Write strobe for the register port |
| busAddr | input | 6 | Byte address within the 64-byte register window |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr |
| irqOut | output | 1 | Interrupt request level |
| smiOut | output | 1 | System-management interrupt request level |
| resetPulse | output | 1 | One-cycle system reset request |

## Verification
The bench targets several corner cases, and each has a visible failure mode:
- Off-by-one expiry: a design that counts one prescaled tick too many or too few sets overflow a cycle early or late, at both the smallest and the clamped largest prescaler setting.
- Reserved exponent: a design that does not clamp settings 14 and 15 waits 16384 or 32768 ticks instead of 8192.
- Stage sequencing: a design that forgets the stage on a timeout write or acknowledge raises the second action where the first belongs.
- Bus write colliding with a tick: a design that lets the tick through in that cycle shortens the next period by one.
- Acknowledge with bit 0 clear: a design that honours it clears flags it must keep.
- Reset pulse: a design that stretches it holds the reset output for more than one cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'b00,
    ACT_IRQ   = 2'b01,
    ACT_SMI   = 2'b10,
    ACT_RESET = 2'b11
  } action_e;

  typedef enum logic {
    STAGE_FIRST  = 1'b0,
    STAGE_SECOND = 1'b1
  } stage_e;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadTimeout;
    logic writeCfg;
    logic ackOverflow;
  } strobe_t;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int TIMEOUT_W = 16,
  parameter int CFG_LIVE_W = 9,
  parameter int EXP_W = 4,
  parameter int EXP_MAX = 13
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tickIn,
  input  strobe_t               strobes,
  input  logic [TIMEOUT_W-1:0]  wrData,
  output logic [TIMEOUT_W-1:0]  timeoutVal,
  output logic [CFG_LIVE_W-1:0] cfgVal,
  output logic                  expire
);

  localparam int PRE_W = (EXP_MAX < 1) ? 1 : EXP_MAX;
  localparam int HALT_BIT = EXP_W + 4;

  logic [TIMEOUT_W-1:0]  timeoutReg;
  logic [TIMEOUT_W-1:0]  cnt;
  logic [CFG_LIVE_W-1:0] cfgReg;
  logic [PRE_W-1:0]      preCnt;
  logic [EXP_W-1:0]      rawExp;
  logic [EXP_W-1:0]      effExp;
  logic [PRE_W-1:0]      preLimit;
  logic                  counting;
  logic                  preWrap;

  assign rawExp = cfgReg[EXP_W-1:0];
  assign effExp = (int'(rawExp) > EXP_MAX) ? EXP_W'(EXP_MAX) : rawExp;
  assign preLimit = PRE_W'((33'd1 << effExp) - 33'd1);

  assign counting = tickIn && (cnt != '0) && !cfgReg[HALT_BIT]
                    && !strobes.loadTimeout && !strobes.ackOverflow;
  assign preWrap  = counting && (preCnt >= preLimit);
  assign expire   = preWrap && (cnt == TIMEOUT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timeoutReg <= '0;
      cnt        <= '0;
      cfgReg     <= '0;
      preCnt     <= '0;
    end else begin
      if (strobes.writeCfg) cfgReg <= wrData[CFG_LIVE_W-1:0];
      if (strobes.loadTimeout) begin
        timeoutReg <= wrData;
        cnt        <= wrData;
        preCnt     <= '0;
      end else if (counting) begin
        if (preWrap) begin
          preCnt <= '0;
          cnt    <= expire ? timeoutReg : cnt - TIMEOUT_W'(1);
        end else begin
          preCnt <= preCnt + PRE_W'(1);
        end
      end
    end
  end

  assign timeoutVal = timeoutReg;
  assign cfgVal     = cfgReg;

endmodule

// File: rtl/wdog_control.sv
module wdog_control
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] TIMEOUT_ADDR = 6'h00,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 6'h02,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 6'h04
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              ackBit,
  input  logic              expire,
  input  action_e           firstAction,
  input  action_e           secondAction,
  output strobe_t           strobes,
  output logic [3:0]        statusFlags,
  output logic              irqOut,
  output logic              smiOut,
  output logic              resetPulse
);

  stage_e  stage;
  action_e chosen;
  logic    ovfFlag, irqFlag, smiFlag, rstFlag;

  always_comb begin
    strobes.loadTimeout = busWrite && (busAddr == TIMEOUT_ADDR);
    strobes.writeCfg    = busWrite && (busAddr == CFG_ADDR);
    strobes.ackOverflow = busWrite && (busAddr == STATUS_ADDR) && ackBit;
  end

  assign chosen = (stage == STAGE_SECOND) ? secondAction : firstAction;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage      <= STAGE_FIRST;
      ovfFlag    <= 1'b0;
      irqFlag    <= 1'b0;
      smiFlag    <= 1'b0;
      rstFlag    <= 1'b0;
      resetPulse <= 1'b0;
    end else begin
      resetPulse <= 1'b0;
      if (strobes.loadTimeout) stage <= STAGE_FIRST;
      if (strobes.ackOverflow) begin
        stage   <= STAGE_FIRST;
        ovfFlag <= 1'b0;
        irqFlag <= 1'b0;
        smiFlag <= 1'b0;
        rstFlag <= 1'b0;
      end else if (expire) begin
        ovfFlag <= 1'b1;
        stage   <= STAGE_SECOND;
        unique case (chosen)
          ACT_IRQ:   irqFlag <= 1'b1;
          ACT_SMI:   smiFlag <= 1'b1;
          ACT_RESET: begin
            rstFlag    <= 1'b1;
            resetPulse <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign statusFlags = {rstFlag, smiFlag, irqFlag, ovfFlag};
  assign irqOut = irqFlag;
  assign smiOut = smiFlag;

endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int EXP_W = 4,
  parameter int EXP_MAX = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              smiOut,
  output logic              resetPulse
);

  localparam int CFG_LIVE_W = EXP_W + 5;
  localparam logic [ADDR_W-1:0] TIMEOUT_ADDR = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] CFG_ADDR     = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STATUS_ADDR  = ADDR_W'(4);

  strobe_t               strobes;
  logic [DATA_W-1:0]     timeoutVal;
  logic [CFG_LIVE_W-1:0] cfgVal;
  logic                  expire;
  logic [3:0]            statusFlags;
  action_e               firstAction, secondAction;

  assign firstAction  = action_e'(cfgVal[EXP_W+1:EXP_W]);
  assign secondAction = action_e'(cfgVal[EXP_W+3:EXP_W+2]);

  wdog_datapath #(
    .TIMEOUT_W(DATA_W), .CFG_LIVE_W(CFG_LIVE_W), .EXP_W(EXP_W), .EXP_MAX(EXP_MAX)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .strobes(strobes),
    .wrData(busWdata), .timeoutVal(timeoutVal), .cfgVal(cfgVal), .expire(expire)
  );

  wdog_control #(
    .ADDR_W(ADDR_W), .TIMEOUT_ADDR(TIMEOUT_ADDR), .CFG_ADDR(CFG_ADDR),
    .STATUS_ADDR(STATUS_ADDR)
  ) i_control (
    .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
    .ackBit(busWdata[0]), .expire(expire), .firstAction(firstAction),
    .secondAction(secondAction), .strobes(strobes), .statusFlags(statusFlags),
    .irqOut(irqOut), .smiOut(smiOut), .resetPulse(resetPulse)
  );

  always_comb begin
    unique case (busAddr)
      TIMEOUT_ADDR: busRdata = timeoutVal;
      CFG_ADDR:     busRdata = DATA_W'(cfgVal);
      STATUS_ADDR:  busRdata = DATA_W'(statusFlags);
      default:      busRdata = '0;
    endcase
  end

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic              irqOut,
  input logic              smiOut,
  input logic              resetPulse
);

  logic ackWrite, loadWrite;
  assign ackWrite  = busWrite && (busAddr == ADDR_W'(4)) && busWdata[0];
  assign loadWrite = busWrite && (busAddr == ADDR_W'(0));

  assert_ack_drops_R10: assert property (@(posedge clk) disable iff (!rstN)
    ackWrite |=> (!irqOut && !smiOut));

  assert_irq_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !ackWrite) |=> irqOut);

  assert_smi_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    (smiOut && !ackWrite) |=> smiOut);

  assert_load_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadWrite |=> !resetPulse);

endmodule

bind wdog_top wdog_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_checker (
  .clk(clk), .rstN(rstN), .busWrite(busWrite), .busAddr(busAddr),
  .busWdata(busWdata), .irqOut(irqOut), .smiOut(smiOut), .resetPulse(resetPulse)
);

// File: tb/test_wdog_top.sv
`timescale 1ns/1ps
module test_wdog_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickIn = 1'b0;
  logic        busWrite = 1'b0;
  logic [5:0]  busAddr = 6'h04;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata;
  logic        irqOut, smiOut, resetPulse;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wdog_top i_wdog_top (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqOut(irqOut), .smiOut(smiOut), .resetPulse(resetPulse)
  );

  // Behavioural reference model
  int mTimeout, mCfg, mCnt, mPre, mStage;
  bit mOvf, mIrq, mSmi, mRst, mPulse;

  function automatic int modelRead(int a);
    if (a == 0) return mTimeout;
    if (a == 2) return mCfg;
    if (a == 4) return (int'(mRst) << 3) | (int'(mSmi) << 2) | (int'(mIrq) << 1) | int'(mOvf);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mTimeout = 0; mCfg = 0; mCnt = 0; mPre = 0; mStage = 0;
      mOvf = 0; mIrq = 0; mSmi = 0; mRst = 0; mPulse = 0;
    end else begin
      bit blocked;
      mPulse = 0;
      blocked = busWrite && (busAddr == 0 || (busAddr == 4 && busWdata[0]));
      if (tickIn && !blocked && mCnt != 0 && ((mCfg >> 8) & 1) == 0) begin
        int e;
        e = mCfg & 15;
        if (e > 13) e = 13;
        mPre = mPre + 1;
        if (mPre >= (1 << e)) begin
          mPre = 0;
          mCnt = mCnt - 1;
          if (mCnt == 0) begin
            int act;
            mCnt = mTimeout;
            mOvf = 1;
            act = (mStage != 0) ? ((mCfg >> 6) & 3) : ((mCfg >> 4) & 3);
            mStage = 1;
            if (act == 1) mIrq = 1;
            if (act == 2) mSmi = 1;
            if (act == 3) begin mRst = 1; mPulse = 1; end
          end
        end
      end
      if (busWrite) begin
        if (busAddr == 0) begin
          mTimeout = busWdata; mCnt = busWdata; mPre = 0; mStage = 0;
        end else if (busAddr == 2) begin
          mCfg = busWdata & 16'h01FF;
        end else if (busAddr == 4 && busWdata[0]) begin
          mOvf = 0; mIrq = 0; mSmi = 0; mRst = 0; mStage = 0;
        end
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    check("R8 irqOut vs model", int'(irqOut), int'(mIrq));
    check("R8 smiOut vs model", int'(smiOut), int'(mSmi));
    check("R9 resetPulse vs model", int'(resetPulse), int'(mPulse));
    check("R2 busRdata vs model", int'(busRdata), modelRead(int'(busAddr)));
  endtask

  task automatic step(bit tick, bit wr, logic [5:0] a, logic [15:0] d);
    tickIn = tick; busWrite = wr; busAddr = a; busWdata = d;
    @(negedge clk);
    compareModel();
    tickIn = 1'b0; busWrite = 1'b0; busAddr = 6'h04; busWdata = 16'h0;
  endtask

  task automatic wr(logic [5:0] a, logic [15:0] d);
    step(1'b0, 1'b1, a, d);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 6'h04, 16'h0);
  endtask

  task automatic expectReg(logic [5:0] a, int exp, string tag);
    busAddr = a;
    #0.5;
    check(tag, int'(busRdata), exp);
    busAddr = 6'h04;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired before the sequence completed");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step(1'b0, 1'b0, 6'h04, 16'h0);
    rstN = 1'b1;
    // R1 reset state
    expectReg(6'h00, 0, "R1 timeout after reset");
    expectReg(6'h02, 0, "R1 config after reset");
    expectReg(6'h04, 0, "R1 status after reset");
    check("R1 outputs low after reset", int'({irqOut, smiOut, resetPulse}), 0);
    ticks(5);
    expectReg(6'h04, 0, "R1 counter stopped after reset");

    // R3 reserved fields, R2 map
    wr(6'h02, 16'hFFFF);
    expectReg(6'h02, 16'h01FF, "R3 config reserved bits hold");
    wr(6'h04, 16'h00F0);
    expectReg(6'h04, 0, "R3 status reserved bits hold");
    expectReg(6'h06, 0, "R2 unmapped address reads zero");

    // R7 two stages: first irq, second reset
    wr(6'h02, 16'h00D0);
    wr(6'h00, 16'd3);
    expectReg(6'h00, 3, "R2 timeout readback");
    ticks(2);
    expectReg(6'h04, 0, "R7 no expiry before T");
    ticks(1);
    expectReg(6'h04, 16'h03, "R7 first stage irq");
    check("R8 irq level", int'(irqOut), 1);
    ticks(3);
    check("R9 reset pulse high", int'(resetPulse), 1);
    expectReg(6'h04, 16'h0B, "R9 second stage reset flag");
    step(1'b0, 1'b0, 6'h04, 16'h0);
    check("R9 reset pulse one cycle", int'(resetPulse), 0);
    check("R8 irq still held", int'(irqOut), 1);

    // R10 acknowledge rules
    wr(6'h04, 16'h000E);
    expectReg(6'h04, 16'h0B, "R10 write with bit0 clear ignored");
    wr(6'h04, 16'h0001);
    expectReg(6'h04, 0, "R10 acknowledge clears flags");
    check("R10 irq dropped", int'(irqOut), 0);
    ticks(3);
    expectReg(6'h04, 16'h03, "R10 rearmed to first stage");
    wr(6'h04, 16'h0001);

    // R6 restart
    wr(6'h00, 16'd4);
    ticks(3);
    wr(6'h00, 16'd4);
    ticks(3);
    expectReg(6'h04, 0, "R6 timeout write restarts count");
    ticks(1);
    expectReg(6'h04, 16'h03, "R6 expiry after restart");
    wr(6'h00, 16'd2);
    ticks(2);
    expectReg(6'h04, 16'h03, "R6 timeout write rearms first stage");
    wr(6'h04, 16'h0001);
    wr(6'h00, 16'd0);
    ticks(20);
    expectReg(6'h04, 0, "R6 zero timeout stops");

    // R4 prescaler
    wr(6'h02, 16'h0012);
    wr(6'h00, 16'd2);
    ticks(7);
    expectReg(6'h04, 0, "R4 divide by 4 early");
    ticks(1);
    expectReg(6'h04, 16'h03, "R4 divide by 4 expiry");
    wr(6'h04, 16'h0001);
    wr(6'h02, 16'h001F);
    wr(6'h00, 16'd1);
    ticks(8191);
    expectReg(6'h04, 0, "R4 clamped setting early");
    ticks(1);
    expectReg(6'h04, 16'h03, "R4 setting 15 acts as 13");
    wr(6'h04, 16'h0001);

    // R5 halt
    wr(6'h02, 16'h0110);
    wr(6'h00, 16'd1);
    ticks(30);
    expectReg(6'h04, 0, "R5 halted count");
    wr(6'h02, 16'h0010);
    ticks(1);
    expectReg(6'h04, 16'h03, "R5 resumes when enabled");
    wr(6'h04, 16'h0001);

    // R7/R8 SMI then irq
    wr(6'h02, 16'h0060);
    wr(6'h00, 16'd2);
    ticks(2);
    expectReg(6'h04, 16'h05, "R8 first stage smi");
    check("R8 smi level", int'(smiOut), 1);
    ticks(2);
    expectReg(6'h04, 16'h07, "R7 second stage irq");
    wr(6'h04, 16'h0001);

    // R7 no action
    wr(6'h02, 16'h0000);
    wr(6'h00, 16'd1);
    ticks(2);
    expectReg(6'h04, 16'h01, "R7 no action only overflow");
    wr(6'h04, 16'h0001);

    // R9 sparse ticks, first stage reset
    wr(6'h02, 16'h0030);
    wr(6'h00, 16'd2);
    step(1'b1, 1'b0, 6'h04, 16'h0);
    step(1'b0, 1'b0, 6'h04, 16'h0);
    step(1'b0, 1'b0, 6'h04, 16'h0);
    step(1'b1, 1'b0, 6'h04, 16'h0);
    check("R9 pulse on first stage", int'(resetPulse), 1);
    expectReg(6'h04, 16'h09, "R9 reset flag set");
    wr(6'h04, 16'h0001);

    // R6/R10 tick colliding with writes
    wr(6'h02, 16'h0010);
    step(1'b1, 1'b1, 6'h00, 16'd1);
    expectReg(6'h04, 0, "R6 tick ignored during timeout write");
    ticks(1);
    expectReg(6'h04, 16'h03, "R6 expiry after collision");
    step(1'b1, 1'b1, 6'h04, 16'h0001);
    expectReg(6'h04, 0, "R10 tick ignored during acknowledge");
    ticks(1);
    expectReg(6'h04, 16'h03, "R10 count resumes after acknowledge");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule